// File: doc/BRIEF.md
# MOS Switch Strength Reducer

This block is a combinational model of a single one-way transistor switch as a switch-level simulator sees it. Each cycle it takes a data value with a drive strength, one or two gate controls and a code that picks the kind of switch. It returns the value that appears on the far side of the switch, plus the strength range of that value. Three kinds are modelled. The n-type switch conducts on a high gate. The p-type switch conducts on a low gate. The complementary pass switch has a true enable and an inverted enable.

A switch does not amplify. A supply-level input leaves the switch one step weaker, at strong level, and every other strength passes through unchanged. When the gate is neither firmly on nor firmly off, the output is uncertain: it may be driven, or it may be high impedance. The block reports this as a weak-side range (L or H) that runs from the reduced strength down to high impedance. An emulator of strength-aware nets instantiates the block once per switch and feeds the result into its net resolver.

Top module: `mos_strength_switch`

## Requirements
- R1: The switch kind code `sw_kind` is 0 for n-type, 1 for p-type and 2 for the complementary pass switch. Code 3 is reserved and behaves as a switch that is always off.
- R2: Logic values on `din_val`, `gate_t` and `gate_n` are coded 0 = logic 0, 1 = logic 1, 2 = unknown (X), 3 = floating (Z). An n-type switch conducts when `gate_t` is 1, is off when it is 0, and is undetermined when it is X or Z.
- R3: A p-type switch conducts when `gate_t` is 0, is off when it is 1, and is undetermined when it is X or Z.
- R4: A pass switch conducts when `gate_t` is 1 or `gate_n` is 0. It is off when `gate_t` is 0 and `gate_n` is 1. In every other case it is undetermined. For the n-type and p-type kinds, `gate_n` has no effect on any output.
- R5: Strength codes are 7 supply, 6 strong, 5 pull, 4 large, 3 weak, 2 medium, 1 small, 0 HiZ. A passed input of supply strength (7) comes out at strong strength (6) with the same value, so no output strength is ever 7.
- R6: A passed input of any strength below supply keeps its strength code unchanged.
- R7: When the switch is off, or the data is Z, `dout_val` is 3 (Z) and both `dout_s0` and `dout_s1` are 0.
- R8: When the switch conducts, output codes follow the data. Data 0 gives `dout_val` 0 with `dout_s0` set to the reduced strength and `dout_s1` 0. Data 1 gives `dout_val` 1 with `dout_s1` set to the reduced strength and `dout_s0` 0. Data X gives `dout_val` 2 with both strengths at the reduced strength.
- R9: When the switch is undetermined, the output is a range that reaches down to HiZ. Data 0 gives `dout_val` 4 (L) with `dout_s0` at the reduced strength and `dout_s1` 0. Data 1 gives `dout_val` 5 (H) with `dout_s1` at the reduced strength and `dout_s0` 0. Data X gives `dout_val` 2 with both strengths at the reduced strength.
- R10: The block holds no state. Its outputs follow a change of input within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dout_val | output | 3 | Output value code: 0, 1, X=2, Z=3, L=4, H=5 |
| dout_s0 | output | STR_W | Strength at the 0 end of the output range |
| dout_s1 | output | STR_W | Strength at the 1 end of the output range |
| din_val | input | 2 | Data input value code |
| din_str | input | STR_W | Data input strength code |
| gate_t | input | 2 | Gate for n-type and p-type switches; true enable for the pass switch |
| gate_n | input | 2 | Inverted enable, used only by the pass switch |
| sw_kind | input | 2 | Switch kind select |

## Verification
Assertions in the RTL check, whenever the inputs are known, that:
- no output strength reaches supply level or goes above the input strength;
- the reducer changes only the supply code;
- the reserved kind never conducts;
- an off switch always yields Z at HiZ strength;
- L and H appear only when the gate is undetermined.

The exact mapping of every value, gate and strength combination to an output code is shown only by the bench. It sweeps all 2048 combinations of kind, both enables, data value and strength against a behavioural reference. That sweep also shows that the inverted enable has no effect on the single-gate kinds, and that the outputs follow the inputs within the same cycle.

// File: rtl/mss_pkg.sv
package mss_pkg;

   // logic value carried on the data and gate pins
   typedef enum logic [1:0] {
      LV_0 = 2'd0,
      LV_1 = 2'd1,
      LV_X = 2'd2,
      LV_Z = 2'd3
   } lval_e;

   // value reported at the switch output
   typedef enum logic [2:0] {
      OV_0 = 3'd0,
      OV_1 = 3'd1,
      OV_X = 3'd2,
      OV_Z = 3'd3,
      OV_L = 3'd4,
      OV_H = 3'd5
   } oval_e;

   // conduction state of the channel
   typedef enum logic [1:0] {
      CD_OFF   = 2'd0,
      CD_ON    = 2'd1,
      CD_MAYBE = 2'd2
   } cond_e;

   // switch kind select
   typedef enum logic [1:0] {
      SK_N   = 2'd0,
      SK_P   = 2'd1,
      SK_T   = 2'd2,
      SK_RSV = 2'd3
   } skind_e;

   localparam int NUM_KINDS = 4;

   // conduction of one gate; on_lvl is the level that opens the channel
   function automatic cond_e gate_cond(input logic [1:0] g, input logic on_lvl);
      cond_e c;
      if (g == {1'b0, on_lvl})
         c = CD_ON;
      else if (g == {1'b0, ~on_lvl})
         c = CD_OFF;
      else
         c = CD_MAYBE;
      return c;
   endfunction

endpackage

// File: rtl/mss_cond_dec.sv
module mss_cond_dec
   import mss_pkg::*;
#(
   parameter int KINDS = NUM_KINDS
) (
   input  logic [1:0] kind,
   input  logic [1:0] gate_t,
   input  logic [1:0] gate_n,
   output cond_e      cond
);

   localparam int KSEL_W = $clog2(KINDS);

   if (KINDS != 4) begin : g_bad_kinds
      $error("mss_cond_dec: KINDS must be 4");
   end
   if (KSEL_W != 2) begin : g_bad_ksel
      $error("mss_cond_dec: kind select must be 2 bits");
   end

   cond_e per_kind [KINDS];

   for (genvar k = 0; k < KINDS; k++) begin : g_kind
      if (k == int'(SK_N)) begin : g_n
         assign per_kind[k] = gate_cond(gate_t, 1'b1);
      end else if (k == int'(SK_P)) begin : g_p
         assign per_kind[k] = gate_cond(gate_t, 1'b0);
      end else if (k == int'(SK_T)) begin : g_t
         cond_e c_true;
         cond_e c_inv;
         assign c_true = gate_cond(gate_t, 1'b1);
         assign c_inv  = gate_cond(gate_n, 1'b0);
         always_comb begin
            if (c_true == CD_ON || c_inv == CD_ON)
               per_kind[k] = CD_ON;
            else if (c_true == CD_OFF && c_inv == CD_OFF)
               per_kind[k] = CD_OFF;
            else
               per_kind[k] = CD_MAYBE;
         end
      end else begin : g_rsv
         assign per_kind[k] = CD_OFF;
      end
   end

   assign cond = per_kind[kind];

   always_comb begin
      if (!$isunknown({kind, gate_t, gate_n})) begin
         // R1
         rsv_never_conducts_chk: assert (kind != 2'd3 || cond == CD_OFF)
            else $error("reserved kind conducted");
         // R4
         tgate_firm_on_chk: assert (!(kind == 2'd2 && (gate_t == 2'd1 || gate_n == 2'd0)) || cond == CD_ON)
            else $error("pass switch not on with an enable asserted");
      end
   end

endmodule

// File: rtl/mss_str_reduce.sv
module mss_str_reduce #(
   parameter int STR_W = 3
) (
   input  logic [STR_W-1:0] s_in,
   output logic [STR_W-1:0] s_out
);

   localparam logic [STR_W-1:0] SUPPLY_LVL = {STR_W{1'b1}};
   localparam logic [STR_W-1:0] STRONG_LVL = SUPPLY_LVL - 1'b1;

   if (STR_W != 3) begin : g_bad_w
      $error("mss_str_reduce: strength scale needs exactly 3 bits");
   end

   assign s_out = (s_in == SUPPLY_LVL) ? STRONG_LVL : s_in;

   always_comb begin
      if (!$isunknown(s_in)) begin
         // R5
         no_supply_out_chk: assert (s_out != SUPPLY_LVL)
            else $error("supply strength leaked through switch");
         // R6
         keep_nonsupply_chk: assert (s_in == SUPPLY_LVL || s_out == s_in)
            else $error("non-supply strength altered");
      end
   end

endmodule

// File: rtl/mss_out_form.sv
module mss_out_form
   import mss_pkg::*;
#(
   parameter int STR_W = 3
) (
   input  cond_e            cond,
   input  logic [1:0]       dval,
   input  logic [STR_W-1:0] rstr,
   output logic [2:0]       oval,
   output logic [STR_W-1:0] os0,
   output logic [STR_W-1:0] os1
);

   localparam logic [STR_W-1:0] HIZ_LVL = '0;

   always_comb begin
      oval = OV_Z;
      os0  = HIZ_LVL;
      os1  = HIZ_LVL;
      if (cond != CD_OFF && dval != LV_Z) begin
         unique case (dval)
            LV_0: begin
               oval = (cond == CD_ON) ? OV_0 : OV_L;
               os0  = rstr;
            end
            LV_1: begin
               oval = (cond == CD_ON) ? OV_1 : OV_H;
               os1  = rstr;
            end
            default: begin
               oval = OV_X;
               os0  = rstr;
               os1  = rstr;
            end
         endcase
      end
   end

   always_comb begin
      if (!$isunknown({cond, dval, rstr})) begin
         // R7
         off_gives_hiz_chk: assert (cond != CD_OFF || (oval == OV_Z && os0 == HIZ_LVL && os1 == HIZ_LVL))
            else $error("off switch drove a value");
         // R9
         weak_only_maybe_chk: assert (!(oval == OV_L || oval == OV_H) || cond == CD_MAYBE)
            else $error("L/H output from a firm gate");
      end
   end

endmodule

// File: rtl/mos_strength_switch.sv
module mos_strength_switch
   import mss_pkg::*;
#(
   parameter int STR_W = 3
) (
   output logic [2:0]       dout_val,
   output logic [STR_W-1:0] dout_s0,
   output logic [STR_W-1:0] dout_s1,
   input  logic [1:0]       din_val,
   input  logic [STR_W-1:0] din_str,
   input  logic [1:0]       gate_t,
   input  logic [1:0]       gate_n,
   input  logic [1:0]       sw_kind
);

   localparam logic [STR_W-1:0] SUPPLY_LVL = {STR_W{1'b1}};

   cond_e            cond;
   logic [STR_W-1:0] red_str;

   mss_cond_dec #(.KINDS(NUM_KINDS)) u_cond (
      .kind   (sw_kind),
      .gate_t (gate_t),
      .gate_n (gate_n),
      .cond   (cond)
   );

   mss_str_reduce #(.STR_W(STR_W)) u_red (
      .s_in  (din_str),
      .s_out (red_str)
   );

   mss_out_form #(.STR_W(STR_W)) u_form (
      .cond (cond),
      .dval (din_val),
      .rstr (red_str),
      .oval (dout_val),
      .os0  (dout_s0),
      .os1  (dout_s1)
   );

   always_comb begin
      if (!$isunknown({din_val, din_str, gate_t, gate_n, sw_kind})) begin
         // R5
         out_below_supply_chk: assert (dout_s0 != SUPPLY_LVL && dout_s1 != SUPPLY_LVL)
            else $error("output at supply strength");
         // R6
         no_gain_chk: assert (dout_s0 <= din_str && dout_s1 <= din_str)
            else $error("switch output stronger than input");
         // R8
         zero_side_only_chk: assert (!(din_val == 2'd0) || dout_s1 == '0)
            else $error("data 0 produced 1-side strength");
      end
   end

endmodule

// File: tb/mos_strength_switch_tb_top.sv
module mos_strength_switch_tb_top;

   localparam int STR_W = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #10 clk = ~clk;   // 50 MHz

   logic [2:0]       dout_val;
   logic [STR_W-1:0] dout_s0, dout_s1;
   logic [1:0]       din_val = '0;
   logic [STR_W-1:0] din_str = '0;
   logic [1:0]       gate_t = '0, gate_n = '0, sw_kind = '0;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   mos_strength_switch #(.STR_W(STR_W)) dut_i (
      .dout_val (dout_val),
      .dout_s0  (dout_s0),
      .dout_s1  (dout_s1),
      .din_val  (din_val),
      .din_str  (din_str),
      .gate_t   (gate_t),
      .gate_n   (gate_n),
      .sw_kind  (sw_kind)
   );

   // behavioural reference: 0 off, 1 on, 2 undetermined
   function automatic void ref_model(input int kind, input int gt, input int gn,
                                     input int dv, input int st,
                                     output int ev, output int e0, output int e1,
                                     output string tag);
      int c, a, b, r;
      a = (gt == 1) ? 1 : (gt == 0) ? 0 : 2;
      b = (gn == 0) ? 1 : (gn == 1) ? 0 : 2;
      case (kind)
         0: c = a;
         1: c = (gt == 0) ? 1 : (gt == 1) ? 0 : 2;
         2: c = (a == 1 || b == 1) ? 1 : (a == 0 && b == 0) ? 0 : 2;
         default: c = 0;
      endcase
      r = (st == 7) ? 6 : st;
      if (c == 0 || dv == 3) begin
         ev = 3; e0 = 0; e1 = 0;
      end else if (dv == 2) begin
         ev = 2; e0 = r; e1 = r;
      end else begin
         if (c == 1) ev = dv;
         else        ev = (dv == 0) ? 4 : 5;
         e0 = (dv == 0) ? r : 0;
         e1 = (dv == 1) ? r : 0;
      end
      if (kind == 3)                 tag = "R1";
      else if (c == 0 || dv == 3)    tag = "R7";
      else if (c == 2)               tag = "R9";
      else if (kind == 2)            tag = "R4";
      else if (kind == 1)            tag = "R3";
      else if (st == 7)              tag = "R5";
      else if (dv == 2)              tag = "R8";
      else if (st % 2 == 1)          tag = "R6";
      else                           tag = "R2";
   endfunction

   task automatic check_now(input string note);
      int ev, e0, e1;
      string tag;
      ref_model(int'(sw_kind), int'(gate_t), int'(gate_n), int'(din_val), int'(din_str),
                ev, e0, e1, tag);
      n_tests++;
      if (int'(dout_val) !== ev || int'(dout_s0) !== e0 || int'(dout_s1) !== e1) begin
         n_fail++;
         $display("FAIL %s %s kind=%0d gt=%0d gn=%0d d=%0d s=%0d : got val=%0d s0=%0d s1=%0d exp val=%0d s0=%0d s1=%0d",
                  tag, note, sw_kind, gate_t, gate_n, din_val, din_str,
                  dout_val, dout_s0, dout_s1, ev, e0, e1);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      // reset state: n-type with low gate is off, Z at HiZ (R7)
      @(negedge clk);
      check_now("reset state");
      for (int k = 0; k < 4; k++)
         for (int gt = 0; gt < 4; gt++)
            for (int gn = 0; gn < 4; gn++)
               for (int dv = 0; dv < 4; dv++)
                  for (int st = 0; st < 8; st++) begin
                     @(posedge clk);
                     #1;
                     sw_kind = 2'(k); gate_t = 2'(gt); gate_n = 2'(gn);
                     din_val = 2'(dv); din_str = 3'(st);
                     @(negedge clk);
                     check_now("sweep");
                  end
      // R10: a mid-cycle change shows at the outputs in that same cycle
      @(posedge clk);
      #1 sw_kind = 2'd0; gate_t = 2'd1; gate_n = 2'd0; din_val = 2'd1; din_str = 3'd7;
      #2 check_now("R10 same-cycle");
      #2 din_val = 2'd0; din_str = 3'd3;
      #2 check_now("R10 same-cycle");
      done = 1;
   end

   initial begin : watchdog
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: got timeout exp completion");
      end
      #5;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule